// File: doc/BRIEF.md
# Bus-Synchronized CPU Clock Gater

This block produces the clock for a secondary processor that shares its memory bus with a video controller. While the processor does no memory or I/O transfer, its clock is a gap-free copy of the fast clock. When it starts a memory or I/O transfer, the block freezes the clock and pulls the wait line low until the slow system bus clock shows an edge. From then on, the processor gets one fast-clock pulse per rising bus-clock edge, which is the processor's half of each bus cycle. This continues for as long as the transfer lasts. Once the transfer ends, full speed returns at once.

The bus-available flag from the video controller and the expansion DMA request both drive the bus-request output. The processor therefore gives up the bus while the video controller steals extra cycles. When video is off, bus-available stays high and only the transfer stalls slow the processor. A transfer is never aligned to the bus clock while the DRAM strobes show a refresh cycle. All slow-side inputs pass through two-flop synchronizers into the fast clock domain before they are used.

Top module: `cpu_clk_gater`

## Requirements
- R1: In the free-running state (no transfer pending, bus available), `cpu_clk` is high during every high phase of `clk_fast`.
- R2: A transfer request is `mreq_n` or `iorq_n` low at a `clk_fast` rising edge. Starting with the next fast cycle, `wait_n` goes low and `cpu_clk` stays low. This holds until the synchronized bus clock shows an edge (either direction) with no refresh in progress.
- R3: While paced, `wait_n` is high. `cpu_clk` gives exactly one fast-clock-high pulse in the fast cycle after each synchronized rising edge of `bus_clk` for which no refresh is seen, and no pulse otherwise.
- R4: When the request is released during pacing, free running (R1) resumes from the next fast cycle.
- R5: `busrq_n` goes low exactly while `bus_avail` or `dma_req_n` was low three `clk_fast` rising edges earlier: two synchronizer stages plus the state register. While the bus is yielded, `cpu_clk` keeps running and `wait_n` stays high.
- R6: A refresh is `refresh_ras_n` low while `refresh_cas_n` is high, seen after synchronization. During a refresh, a pending transfer is not aligned to the bus clock and no paced pulse is issued.
- R7: `cpu_clk` is high only inside a high phase of `clk_fast`, and it stays constant across that whole phase. No partial pulse is produced.
- R8: While `rst_n` is low at a rising edge of `clk_fast`, `wait_n` and `busrq_n` are high afterwards, the state returns to free running, and `cpu_clk` keeps following `clk_fast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, source of the processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Slow system bus clock, asynchronous |
| bus_avail | input | 1 | Bus available from the video controller, low while it steals cycles |
| dma_req_n | input | 1 | Expansion DMA request, active low |
| mreq_n | input | 1 | Processor memory request, active low |
| iorq_n | input | 1 | Processor I/O request, active low |
| refresh_ras_n | input | 1 | DRAM row strobe, active low |
| refresh_cas_n | input | 1 | DRAM column strobe, active low |
| cpu_clk | output | 1 | Gated processor clock |
| wait_n | output | 1 | Wait request to the processor, active low |
| busrq_n | output | 1 | Bus request to the processor, active low |

## Verification
The assertions check the following on every cycle: the three-edge latency from bus-available or DMA to `busrq_n`, the frozen clock whenever the wait line was low, the running clock in the free state, the rule that alignment never happens in a refresh cycle, and the reset values. The exact placement of paced pulses on rising bus-clock edges, the release back to full speed, and the full-width shape of each pulse need whole scenarios. The bench checks these against a cycle model, using random transfers, refreshes, video steals and DMA together with directed cases for video-off mode, a refresh blocking alignment, and reset in mid-transfer.

// File: rtl/cgate_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bus-synchronized processor clock gater.
// Assumes: one fast clock domain, all slow inputs synchronized before use.
package cgate_pkg;

    // Stall controller states; order carries no meaning.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,   // clock free at fast rate
        ST_ALIGN = 2'd1,   // transfer pending, clock frozen, waiting for bus edge
        ST_PACED = 2'd2,   // transfer paced by rising bus-clock edges
        ST_YIELD = 2'd3    // bus handed to video controller or DMA
    } gate_state_t;

    localparam int SLOW_INPUTS = 5;   // bus clock, bus avail, dma, ras, cas

endpackage

// File: rtl/cgate_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent; no bus coherency is needed.
module cgate_sync #(
    parameter int          WIDTH   = 5,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= din;
    end

    // Remaining stages form the metastability filter.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
        end
    end

    assign dout = chain[LAST];
endmodule

// File: rtl/cgate_fsm.sv
`timescale 1ns/1ps
// Stall controller: decides, per fast cycle, whether the processor clock runs.
// Assumes: all inputs except req are already synchronized to clk.
module cgate_fsm
    import cgate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_s,      // synchronized bus clock
    input  logic        bus_free,   // bus available and no DMA
    input  logic        ref_busy,   // refresh cycle in progress
    input  logic        req,        // memory or I/O transfer requested
    output gate_state_t state,
    output logic        gate_en     // clock enable for the next fast cycle
);
    logic        bus_d;
    logic        bus_rise;
    logic        bus_edge;
    logic        pace_q;
    gate_state_t nxt;

    // Delayed copy of the synchronized bus clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_d <= 1'b0;
        else        bus_d <= bus_s;
    end

    assign bus_rise = bus_s & ~bus_d;
    assign bus_edge = bus_s ^ bus_d;

    // Next-state selection; yielding the bus overrides every other state.
    always_comb begin
        nxt = state;
        if (!bus_free) begin
            nxt = ST_YIELD;
        end else begin
            unique case (state)
                ST_RUN:   if (req) nxt = ST_ALIGN;
                ST_ALIGN: begin
                    if (!req)                       nxt = ST_RUN;
                    else if (bus_edge && !ref_busy) nxt = ST_PACED;
                end
                ST_PACED: if (!req) nxt = ST_RUN;
                ST_YIELD: nxt = ST_RUN;
                default:  nxt = ST_RUN;
            endcase
        end
    end

    // State register and one-cycle pacing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            pace_q <= 1'b0;
        end else begin
            state  <= nxt;
            pace_q <= (nxt == ST_PACED) && bus_rise && !ref_busy;
        end
    end

    // Clock enable: free and yield run, align freezes, paced pulses once.
    always_comb begin
        unique case (state)
            ST_RUN, ST_YIELD: gate_en = 1'b1;
            ST_PACED:         gate_en = pace_q;
            default:          gate_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/cgate_clkgate.sv
`timescale 1ns/1ps
// Glitch-free clock gate: enable captured while the clock is low.
// Assumes: en is stable before the falling edge of clk.
module cgate_clkgate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic gclk
);
    logic en_q;

    // Enable latch updated on the falling edge; reset keeps the clock on.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en;
    end

    assign gclk = clk & en_q;
endmodule

// File: rtl/cpu_clk_gater.sv
`timescale 1ns/1ps
// Top level: synchronizes slow inputs, runs the stall controller, gates the clock.
// Assumes: mreq_n and iorq_n come from the processor on the gated clock and
// are therefore treated as synchronous to clk_fast.
module cpu_clk_gater
    import cgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_fast,
    input  logic rst_n,
    input  logic bus_clk,
    input  logic bus_avail,
    input  logic dma_req_n,
    input  logic mreq_n,
    input  logic iorq_n,
    input  logic refresh_ras_n,
    input  logic refresh_cas_n,
    output logic cpu_clk,
    output logic wait_n,
    output logic busrq_n
);
    localparam logic [SLOW_INPUTS-1:0] SYNC_RST = 5'b0_1111;

    logic [SLOW_INPUTS-1:0] slow_raw;
    logic [SLOW_INPUTS-1:0] slow_s;
    logic        bus_free;
    logic        ref_busy;
    logic        req;
    logic        gate_en;
    gate_state_t state_q;

    assign slow_raw = {bus_clk, bus_avail, dma_req_n, refresh_ras_n, refresh_cas_n};

    cgate_sync #(
        .WIDTH   (SLOW_INPUTS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .din   (slow_raw),
        .dout  (slow_s)
    );

    assign bus_free = slow_s[3] & slow_s[2];
    assign ref_busy = ~slow_s[1] & slow_s[0];
    assign req      = ~mreq_n | ~iorq_n;

    cgate_fsm u_fsm (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .bus_s    (slow_s[4]),
        .bus_free (bus_free),
        .ref_busy (ref_busy),
        .req      (req),
        .state    (state_q),
        .gate_en  (gate_en)
    );

    cgate_clkgate u_gate (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .en    (gate_en),
        .gclk  (cpu_clk)
    );

    assign wait_n  = (state_q != ST_ALIGN);
    assign busrq_n = (state_q != ST_YIELD);
endmodule

// File: rtl/cpu_clk_gater_chk.sv
`timescale 1ns/1ps
// Property checker for cpu_clk_gater, attached by bind.
// Assumes: asynchronous inputs are stable around clk_fast rising edges.
module cpu_clk_gater_chk
    import cgate_pkg::*;
(
    input logic        clk_fast,
    input logic        rst_n,
    input logic        bus_avail,
    input logic        dma_req_n,
    input logic        cpu_clk,
    input logic        wait_n,
    input logic        busrq_n,
    input gate_state_t st,
    input logic        ref_busy
);
    logic [2:0] since_rst;
    logic       started = 1'b0;

    // Counts rising edges since reset was released, saturating.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)                since_rst <= 3'd0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // Marks that at least one rising edge has occurred.
    always_ff @(posedge clk_fast) started <= 1'b1;

    assert_busrq_latency_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (busrq_n == ($past(bus_avail, 3) && $past(dma_req_n, 3))));

    assert_frozen_on_wait_R2: assert property (@(negedge clk_fast) disable iff (!rst_n)
        (since_rst >= 3'd1 && !$past(wait_n)) |-> !cpu_clk);

    assert_free_runs_R1: assert property (@(negedge clk_fast) disable iff (!rst_n)
        (since_rst >= 3'd1 && $past(st) == ST_RUN) |-> cpu_clk);

    assert_no_align_in_refresh_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (since_rst >= 3'd2 && st == ST_PACED && $past(st) == ST_ALIGN) |-> !$past(ref_busy));

    assert_reset_values_R8: assert property (@(posedge clk_fast)
        (started && !$past(rst_n)) |-> (wait_n && busrq_n && st == ST_RUN));
endmodule

bind cpu_clk_gater cpu_clk_gater_chk u_chk (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .bus_avail (bus_avail),
    .dma_req_n (dma_req_n),
    .cpu_clk   (cpu_clk),
    .wait_n    (wait_n),
    .busrq_n   (busrq_n),
    .st        (state_q),
    .ref_busy  (ref_busy)
);

// File: tb/cpu_clk_gater_test.sv
`timescale 1ns/1ps
// Self-checking bench: cycle model of the requirements, random plus directed stimulus.
module cpu_clk_gater_test;
    localparam int S_RUN = 0, S_ALIGN = 1, S_PACED = 2, S_YIELD = 3;

    logic clk = 1'b0;
    logic rst_n, bus_clk, ba, dma_n, mreq_n, iorq_n, ras_n, cas_n;
    logic cpu_clk, wait_n, busrq_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Model state.
    int m_st = S_RUN, m_prev = S_RUN, m_en_st = S_RUN;
    bit m_pace = 0, m_en = 1, m_valid = 0, m_blocked = 0;
    bit b1 = 0, b2 = 0, bd = 0, a1 = 1, a2 = 1, d1 = 1, d2 = 1;
    bit r1 = 1, r2 = 1, c1 = 1, c2 = 1;
    int bus_cnt = 0;

    always #10 clk = ~clk;

    cpu_clk_gater uut (
        .clk_fast      (clk),
        .rst_n         (rst_n),
        .bus_clk       (bus_clk),
        .bus_avail     (ba),
        .dma_req_n     (dma_n),
        .mreq_n        (mreq_n),
        .iorq_n        (iorq_n),
        .refresh_ras_n (ras_n),
        .refresh_cas_n (cas_n),
        .cpu_clk       (cpu_clk),
        .wait_n        (wait_n),
        .busrq_n       (busrq_n)
    );

    task automatic chk(bit ok, string tag, logic act, logic exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Next state per R2..R6 from pre-edge synchronized values.
    function automatic int next_state(int st, bit hold, bit edge_seen, bit refb, bit req);
        if (hold) return S_YIELD;
        case (st)
            S_RUN:   return req ? S_ALIGN : S_RUN;
            S_ALIGN: return !req ? S_RUN : ((edge_seen && !refb) ? S_PACED : S_ALIGN);
            S_PACED: return req ? S_PACED : S_RUN;
            default: return S_RUN;
        endcase
    endfunction

    function automatic bit enable_for(int st, bit pace);
        return (st == S_RUN || st == S_YIELD) ? 1'b1 : (st == S_PACED ? pace : 1'b0);
    endfunction

    function automatic string clk_tag(int st, int prev);
        if (st == S_RUN && prev == S_PACED) return "R4";
        case (st)
            S_RUN:   return "R1";
            S_ALIGN: return "R2";
            S_PACED: return "R3";
            default: return "R5";
        endcase
    endfunction

    // Monitor: samples mid high phase, then advances the model.
    always @(posedge clk) begin
        logic ca, cb;
        bit hold, rise, edg, refb, req;
        int nxt;
        #5 ca = cpu_clk;
        #3 cb = cpu_clk;
        if (m_valid && !done) begin
            chk(ca === m_en, clk_tag(m_en_st, m_prev), ca, m_en);
            chk(ca === cb, "R7", cb, ca);
        end
        m_prev = m_st;
        if (!rst_n) begin
            m_st = S_RUN; m_pace = 0; m_blocked = 0;
            b1 = 0; b2 = 0; bd = 0; a1 = 1; a2 = 1; d1 = 1; d2 = 1;
            r1 = 1; r2 = 1; c1 = 1; c2 = 1;
            m_en = 1;
        end else begin
            hold = !a2 || !d2;
            rise = b2 && !bd;
            edg  = b2 != bd;
            refb = !r2 && c2;
            req  = !mreq_n || !iorq_n;
            nxt  = next_state(m_st, hold, edg, refb, req);
            m_blocked = (m_st == S_ALIGN) && !hold && req && edg && refb;
            m_pace = (nxt == S_PACED) && rise && !refb;
            m_st = nxt;
            bd = b2; b2 = b1; b1 = bus_clk;
            a2 = a1; a1 = ba; d2 = d1; d1 = dma_n;
            r2 = r1; r1 = ras_n; c2 = c1; c1 = cas_n;
            m_en = enable_for(m_st, m_pace);
        end
        m_en_st = m_st;
        if (!done) begin
            chk(wait_n === (m_st != S_ALIGN), !rst_n ? "R8" : (m_blocked ? "R6" : "R2"),
                wait_n, m_st != S_ALIGN);
            chk(busrq_n === (m_st != S_YIELD), !rst_n ? "R8" : "R5", busrq_n, m_st != S_YIELD);
        end
        m_valid = 1;
    end

    // One fast cycle of stimulus; bus clock toggles every 8 fast cycles.
    task automatic step();
        @(negedge clk);
        #5;
        bus_cnt++;
        if (bus_cnt % 8 == 0) bus_clk = ~bus_clk;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; bus_clk = 0; ba = 1; dma_n = 1; mreq_n = 1; iorq_n = 1;
        ras_n = 1; cas_n = 1;
        steps(4);                       // R8: reset state checked by monitor
        rst_n = 1;
        steps(40);                      // R1: video-off mode, no transfers
        mreq_n = 0; ras_n = 0;          // R6: refresh blocks alignment
        steps(30);
        ras_n = 1;                      // R2/R3: alignment then pacing
        steps(40);
        mreq_n = 1;                     // R4: release
        steps(10);
        dma_n = 0; steps(12); dma_n = 1; // R5: DMA yield
        steps(6);
        iorq_n = 0; steps(20);
        rst_n = 0; steps(3); rst_n = 1;  // R8: reset mid transfer
        iorq_n = 1; steps(6);
        for (int i = 0; i < 4000; i++) begin
            step();
            if (mreq_n && iorq_n) begin
                if ($urandom % 6 == 0) begin
                    if ($urandom % 3 == 0) iorq_n = 0; else mreq_n = 0;
                end
            end else if ($urandom % 9 == 0) begin
                mreq_n = 1; iorq_n = 1;
            end
            ba    = ($urandom % 10 != 0) || !bus_clk;
            dma_n = ($urandom % 60 != 0);
            if ($urandom % 12 == 0) ras_n = ~ras_n;
            cas_n = ($urandom % 15 != 0);
        end
        steps(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule